// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering

This unit sits between an instruction queue and a row of parallel decoders that are not alike. Every cycle it looks at the oldest queue entries. Each entry carries a valid flag and the number of micro-ops the instruction expands to. The unit decides how many of those entries are decoded together.

Slot 0 is the wide decoder and takes any instruction of up to four micro-ops. The remaining slots take only single-micro-op instructions. Steering runs strictly in program order, so the first entry that does not fit its slot ends the group. An instruction longer than four micro-ops goes to a microcode sequencer, which then holds the decode path for several cycles. The sequencer emits up to four micro-ops per cycle and signals done in its final emission cycle. A flush cancels the current sequence and consumes nothing in that cycle.

The queue-side interface works as a valid/ready stream. The queue presents entries on `q_valid`/`q_uops`, and `consume_cnt` acts as the ready: it gives the number of head entries accepted this cycle, always a prefix of the presented entries. The queue must hold any entry that was not consumed unchanged at the same position, and shift by exactly `consume_cnt` at the clock edge. Nothing is consumed while the sequencer is busy or while `flush` is high.

Top module: `dec_steer`

## Requirements
- R1: A valid head entry with an effective count of 1 to 4 is steered to slot 0. An input count of 0 is taken as 1. `slot_valid[0]` goes high, and the count adds to `uop_emit` in the same cycle.
- R2: Slot k (k >= 1) is valid only if slot k-1 is valid and entry k is valid with an effective count of 1. The first entry that fails this test ends the group. Later entries are not decoded, even if they would fit.
- R3: When any slot is valid, `consume_cnt` equals the number of valid slots. `uop_emit` equals the head count plus one per valid upper slot.
- R4: When `q_valid[0]` is low and the sequencer is idle, `consume_cnt`, `slot_valid` and `uop_emit` are all zero.
- R5: A valid head entry with an effective count above 4, seen while the sequencer is idle, is consumed alone. `consume_cnt` is 1, no slot is valid and `uop_emit` is 0. `seq_busy` is high from the next cycle.
- R6: While `seq_busy` is high, `consume_cnt` is 0 and no slot is valid. Each cycle `uop_emit` is the smaller of 4 and the micro-ops still owed.
- R7: `seq_done` is high in exactly the cycle that emits the last micro-ops of a sequence. `seq_busy` is low in the following cycle, and steering resumes then.
- R8: While `flush` is high, `consume_cnt`, `slot_valid`, `uop_emit` and `seq_done` are zero, and no sequence is started. `seq_busy` is low in the next cycle.
- R9: After reset the sequencer is idle: `seq_busy` and `seq_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Cancel sequence, consume nothing this cycle |
| q_valid | input | NSLOT | Valid flag per queue entry, bit 0 is oldest |
| q_uops | input | NSLOT*CNT_W | Micro-op count per entry, entry k in bits [k*CNT_W +: CNT_W] |
| slot_valid | output | NSLOT | Decoder slot k receives entry k this cycle |
| consume_cnt | output | clog2(NSLOT+1) | Entries popped from the queue this cycle |
| uop_emit | output | EMIT_W | Micro-ops produced this cycle |
| seq_busy | output | 1 | Microcode sequencer holds the decode path |
| seq_done | output | 1 | Final emission cycle of a sequence |

## Verification
The bench builds the block with its defaults: three slots, a 5-bit count, a four-micro-op limit for slot 0 and a sequencer rate of four. With a 5-bit count, sequences can run several cycles, so both remainders that are exact multiples of the rate and partial final remainders are reached. Three slots make the full 4-1-1 group, a two-entry group and every order that stops early reachable, including a single-micro-op entry that is stranded behind a wider one. Flush is applied both in the middle of a sequence and over a group that could otherwise be fully decoded.

// File: rtl/dec_steer_pkg.sv
package dec_steer_pkg;

  typedef enum logic {
    MODE_STEER = 1'b0,
    MODE_SEQ   = 1'b1
  } steer_mode_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dec_steer_pick.sv
module dec_steer_pick #(
  parameter int NSLOT   = 3,
  parameter int CNT_W   = 5,
  parameter int BIG_MAX = 4,
  parameter int CONS_W  = 2,
  parameter int EMIT_W  = 3
) (
  input  logic [NSLOT-1:0]       q_valid,
  input  logic [NSLOT*CNT_W-1:0] q_uops,
  output logic [NSLOT-1:0]       take,
  output logic                   big_head,
  output logic [CONS_W-1:0]      take_cnt,
  output logic [EMIT_W-1:0]      take_uops
);

  logic [CNT_W-1:0] eff [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_eff
    logic [CNT_W-1:0] raw;
    assign raw    = q_uops[k*CNT_W +: CNT_W];
    assign eff[k] = (raw == '0) ? CNT_W'(1) : raw;
  end

  assign take[0]  = q_valid[0] && (eff[0] <= CNT_W'(BIG_MAX));
  assign big_head = q_valid[0] && (eff[0] >  CNT_W'(BIG_MAX));

  for (genvar k = 1; k < NSLOT; k++) begin : g_narrow
    assign take[k] = take[k-1] && q_valid[k] && (eff[k] == CNT_W'(1));
  end

  always_comb begin
    take_cnt  = '0;
    take_uops = take[0] ? EMIT_W'(eff[0]) : '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (take[k]) take_cnt = take_cnt + CONS_W'(1);
    end
    for (int k = 1; k < NSLOT; k++) begin
      take_uops = take_uops + EMIT_W'(take[k]);
    end
  end

endmodule

// File: rtl/dec_steer_seq.sv
module dec_steer_seq #(
  parameter int CNT_W    = 5,
  parameter int SEQ_RATE = 4,
  parameter int EMIT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_cnt,
  output logic              busy,
  output logic              done,
  output logic [EMIT_W-1:0] emit
);

  localparam logic [CNT_W-1:0] RATE = CNT_W'(SEQ_RATE);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] step;

  assign busy = (remain != '0);
  assign step = (remain <= RATE) ? remain : RATE;
  assign emit = (busy && !flush) ? EMIT_W'(step) : '0;
  assign done = busy && !flush && (remain <= RATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (flush) begin
      remain <= '0;
    end else if (busy) begin
      remain <= remain - step;
    end else if (load) begin
      remain <= load_cnt;
    end
  end

endmodule

// File: rtl/dec_steer.sv
module dec_steer #(
  parameter int NSLOT    = 3,
  parameter int CNT_W    = 5,
  parameter int BIG_MAX  = 4,
  parameter int SEQ_RATE = 4,
  localparam int CONS_W   = $clog2(NSLOT + 1),
  localparam int EMIT_MAX = dec_steer_pkg::max_i(BIG_MAX + NSLOT - 1, SEQ_RATE),
  localparam int EMIT_W   = $clog2(EMIT_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [NSLOT-1:0]       q_valid,
  input  logic [NSLOT*CNT_W-1:0] q_uops,
  output logic [NSLOT-1:0]       slot_valid,
  output logic [CONS_W-1:0]      consume_cnt,
  output logic [EMIT_W-1:0]      uop_emit,
  output logic                   seq_busy,
  output logic                   seq_done
);
  import dec_steer_pkg::*;

  logic [NSLOT-1:0]  take;
  logic              big_head;
  logic [CONS_W-1:0] take_cnt;
  logic [EMIT_W-1:0] take_uops;
  logic [EMIT_W-1:0] seq_emit;
  logic              seq_load;
  logic              steer_ok;
  steer_mode_e       mode;

  dec_steer_pick #(
    .NSLOT(NSLOT), .CNT_W(CNT_W), .BIG_MAX(BIG_MAX),
    .CONS_W(CONS_W), .EMIT_W(EMIT_W)
  ) pick_i (
    .q_valid   (q_valid),
    .q_uops    (q_uops),
    .take      (take),
    .big_head  (big_head),
    .take_cnt  (take_cnt),
    .take_uops (take_uops)
  );

  dec_steer_seq #(
    .CNT_W(CNT_W), .SEQ_RATE(SEQ_RATE), .EMIT_W(EMIT_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (seq_load),
    .load_cnt (q_uops[CNT_W-1:0]),
    .busy     (seq_busy),
    .done     (seq_done),
    .emit     (seq_emit)
  );

  assign mode     = seq_busy ? MODE_SEQ : MODE_STEER;
  assign steer_ok = !flush && (mode == MODE_STEER);
  assign seq_load = steer_ok && big_head;

  always_comb begin
    slot_valid  = '0;
    consume_cnt = '0;
    uop_emit    = '0;
    if (!flush) begin
      if (mode == MODE_SEQ) begin
        uop_emit = seq_emit;
      end else if (big_head) begin
        consume_cnt = CONS_W'(1);
      end else begin
        slot_valid  = take;
        consume_cnt = take_cnt;
        uop_emit    = take_uops;
      end
    end
  end

endmodule

// File: rtl/dec_steer_chk.sv
module dec_steer_chk #(
  parameter int NSLOT  = 3,
  parameter int CNT_W  = 5,
  parameter int CONS_W = 2,
  parameter int EMIT_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic [NSLOT-1:0]       q_valid,
  input logic [NSLOT*CNT_W-1:0] q_uops,
  input logic [NSLOT-1:0]       slot_valid,
  input logic [CONS_W-1:0]      consume_cnt,
  input logic [EMIT_W-1:0]      uop_emit,
  input logic                   seq_busy,
  input logic                   seq_done
);

  for (genvar k = 1; k < NSLOT; k++) begin : g_order
    logic [CNT_W-1:0] u;
    assign u = q_uops[k*CNT_W +: CNT_W];
    a_r2_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid[k] |-> (slot_valid[k-1] && q_valid[k] && (u <= CNT_W'(1))));
  end

  a_r3_count_match: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_valid) |-> (32'(consume_cnt) == $countones(slot_valid)));

  a_r4_no_head: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_valid[0] && !seq_busy) |-> (consume_cnt == '0 && uop_emit == '0));

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (consume_cnt == '0 && slot_valid == '0));

  a_r7_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_busy);

  a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (consume_cnt == '0 && uop_emit == '0 && slot_valid == '0 && !seq_done));

  a_r8_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !seq_busy);

  a_r5_escape_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && consume_cnt == CONS_W'(1) && slot_valid == '0) |=> seq_busy);

endmodule

bind dec_steer dec_steer_chk #(
  .NSLOT(NSLOT), .CNT_W(CNT_W), .CONS_W(CONS_W), .EMIT_W(EMIT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .q_valid(q_valid), .q_uops(q_uops),
  .slot_valid(slot_valid), .consume_cnt(consume_cnt), .uop_emit(uop_emit),
  .seq_busy(seq_busy), .seq_done(seq_done)
);

// File: tb/dec_steer_tb_top.sv
module dec_steer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic [2:0] q_valid = '0;
  logic [14:0] q_uops = '0;
  logic [2:0] slot_valid;
  logic [1:0] consume_cnt;
  logic [2:0] uop_emit;
  logic       seq_busy;
  logic       seq_done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_steer dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .q_valid(q_valid), .q_uops(q_uops),
    .slot_valid(slot_valid), .consume_cnt(consume_cnt), .uop_emit(uop_emit),
    .seq_busy(seq_busy), .seq_done(seq_done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive at the falling edge, let combinational outputs settle
  task automatic apply(input logic f, input logic [2:0] v,
                       input int u0, input int u1, input int u2);
    @(negedge clk);
    flush   = f;
    q_valid = v;
    q_uops  = {5'(u2), 5'(u1), 5'(u0)};
    #2;
  endtask

  task automatic expect_out(input string req, input int sv, input int cc,
                            input int em, input int bz, input int dn);
    chk(req, "slot_valid",  int'(slot_valid),  sv);
    chk(req, "consume_cnt", int'(consume_cnt), cc);
    chk(req, "uop_emit",    int'(uop_emit),    em);
    chk(req, "seq_busy",    int'(seq_busy),    bz);
    chk(req, "seq_done",    int'(seq_done),    dn);
  endtask

  task automatic t_reset;
    #3;
    chk("R9", "seq_busy in reset", int'(seq_busy), 0);
    chk("R9", "seq_done in reset", int'(seq_done), 0);
    @(negedge clk); rst_n = 1'b1;
    apply(0, 3'b000, 0, 0, 0);
    expect_out("R9", 0, 0, 0, 0, 0);
  endtask

  task automatic t_groups;
    apply(0, 3'b111, 4, 1, 1); expect_out("R3", 3'b111, 3, 6, 0, 0); // 4-1-1
    apply(0, 3'b011, 4, 1, 7); expect_out("R3", 3'b011, 2, 5, 0, 0); // 4-1
    apply(0, 3'b111, 4, 2, 2); expect_out("R2", 3'b001, 1, 4, 0, 0); // 4-2-2
    apply(0, 3'b011, 4, 2, 0); expect_out("R2", 3'b001, 1, 4, 0, 0); // 4-2
    apply(0, 3'b111, 1, 2, 1); expect_out("R2", 3'b001, 1, 1, 0, 0); // stranded
    apply(0, 3'b111, 2, 1, 2); expect_out("R2", 3'b011, 2, 3, 0, 0);
    apply(0, 3'b101, 3, 1, 1); expect_out("R2", 3'b001, 1, 3, 0, 0); // hole
    apply(0, 3'b111, 0, 0, 1); expect_out("R1", 3'b111, 3, 3, 0, 0); // zero = one
    apply(0, 3'b001, 4, 0, 0); expect_out("R1", 3'b001, 1, 4, 0, 0);
  endtask

  task automatic t_no_head;
    apply(0, 3'b110, 1, 1, 1); expect_out("R4", 0, 0, 0, 0, 0);
  endtask

  task automatic t_escape_ten;
    apply(0, 3'b111, 10, 1, 1); expect_out("R5", 0, 1, 0, 0, 0);
    apply(0, 3'b111, 1, 1, 1);  expect_out("R6", 0, 0, 4, 1, 0);
    apply(0, 3'b111, 1, 1, 1);  expect_out("R6", 0, 0, 4, 1, 0);
    apply(0, 3'b111, 1, 1, 1);  expect_out("R7", 0, 0, 2, 1, 1);
    apply(0, 3'b111, 1, 1, 1);  expect_out("R7", 3'b111, 3, 3, 0, 0);
  endtask

  task automatic t_escape_edges;
    apply(0, 3'b001, 5, 0, 0); expect_out("R5", 0, 1, 0, 0, 0);
    apply(0, 3'b000, 0, 0, 0); expect_out("R6", 0, 0, 4, 1, 0);
    apply(0, 3'b000, 0, 0, 0); expect_out("R7", 0, 0, 1, 1, 1);
    apply(0, 3'b000, 0, 0, 0); expect_out("R7", 0, 0, 0, 0, 0);
    apply(0, 3'b001, 8, 0, 0); expect_out("R5", 0, 1, 0, 0, 0);
    apply(0, 3'b000, 0, 0, 0); expect_out("R6", 0, 0, 4, 1, 0);
    apply(0, 3'b000, 0, 0, 0); expect_out("R7", 0, 0, 4, 1, 1);
    apply(0, 3'b000, 0, 0, 0); expect_out("R7", 0, 0, 0, 0, 0);
  endtask

  task automatic t_flush;
    apply(0, 3'b001, 31, 0, 0); expect_out("R5", 0, 1, 0, 0, 0);
    apply(0, 3'b111, 1, 1, 1);  expect_out("R6", 0, 0, 4, 1, 0);
    apply(1, 3'b111, 1, 1, 1);  expect_out("R8", 0, 0, 0, 1, 0);
    apply(0, 3'b111, 4, 1, 1);  expect_out("R8", 3'b111, 3, 6, 0, 0);
    apply(1, 3'b111, 4, 1, 1);  expect_out("R8", 0, 0, 0, 0, 0);
    apply(1, 3'b001, 9, 0, 0);  expect_out("R8", 0, 0, 0, 0, 0);
    apply(0, 3'b000, 0, 0, 0);  expect_out("R8", 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_groups();
    t_no_head();
    t_escape_ten();
    t_escape_edges();
    t_flush();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule